// File: doc/BRIEF.md
# Masked Alarm Interrupt Controller

The block watches the running time of a calendar clock and raises an interrupt when it matches a programmed alarm. Four alarm registers hold a seconds, minutes, hours and date value. The top bit of each register is a mask bit. The mask pattern selects how often the alarm fires: every second, or when the selected time fields match. Matching is evaluated only on a one-cycle seconds tick. A match sets the alarm flag.

The interrupt output is modelled as an active-low open-drain pin. `irq_drive` high means the pin is pulled low, and `irq_drive` low means the pin is released. Two enable bits gate the pin. One applies to normal power. Both are needed while the system runs from its backup supply. The enable bits clear when main power returns. Any read or write of the flags register releases the pin at once. The flag itself is cleared once that access has ended.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset the alarm flag is 0, `irq_drive` is 0, and addresses 2h to 6h read 00h.
- R2: With mask bits (date, hours, minutes, seconds register bit 7) equal to 1111, every tick sets the alarm flag. Any mask pattern outside the five legal ones does the same.
- R3: Mask 1110 needs a seconds match. Mask 1100 needs minutes and seconds to match. Mask 1000 adds hours. Mask 0000 adds the date. Seconds and minutes compare bits 6:0, and hours and date compare bits 5:0.
- R4: The alarm flag is set only by a tick. It is visible, together with `irq_drive`, in the cycle after the tick is sampled.
- R5: Under main power (`power_good` = 1), `irq_drive` is 1 only when the alarm flag is 1 and the alarm enable (address 6h bit 7) is 1.
- R6: Under backup power (`power_good` = 0), `irq_drive` is 1 only when the alarm flag, the alarm enable and the backup enable (address 6h bit 5) are all 1.
- R7: A rising `power_good` clears address 6h bits 7 and 5 and keeps its other bits. A tick that matches in that same cycle still sets the alarm flag.
- R8: Address 0h reads `wdog_flag` in bit 7, the alarm flag in bit 6 and `batt_low` in bit 4. Bits 5 and 3:0 read 0. Write data to 0h is discarded.
- R9: While address 0h is accessed, `irq_drive` is 0. The flag stays readable as 1 during that access. The flag is cleared one cycle after `acc_sel` falls, and `irq_drive` stays 0 up to that clear.
- R10: Address 6h stores all eight written bits. Addresses 2h to 5h also read back all eight written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| tm_sec | input | 7 | Current seconds, BCD |
| tm_min | input | 7 | Current minutes, BCD |
| tm_hour | input | 6 | Current hours, BCD |
| tm_date | input | 6 | Current day of month, BCD |
| power_good | input | 1 | 1 = main supply, 0 = backup |
| wdog_flag | input | 1 | Watchdog flag shown in flags register |
| batt_low | input | 1 | Battery-low flag shown in flags register |
| acc_sel | input | 1 | Register access active |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for `acc_addr` |
| irq_drive | output | 1 | 1 = interrupt pin pulled low |

## Verification
The assertions assume that `sec_tick` is a single-cycle pulse. They also assume that `power_good` and the access signals change only between clock edges, and that an access holds its address steady until `acc_sel` falls. The bench drives every input on the falling edge. Each access asserts `acc_sel` for one cycle with a fixed address, and each tick lasts exactly one cycle. The mask sweep covers all sixteen mask patterns. Each pattern is checked against all sixteen combinations of matching and mismatching fields.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DW     = 8;
  localparam int AW     = 4;
  localparam int NFIELD = 4;

  localparam logic [AW-1:0] ADR_FLAGS    = 4'h0;
  localparam logic [AW-1:0] ADR_ALM_BASE = 4'h2;
  localparam logic [AW-1:0] ADR_INTEN    = 4'h6;

  localparam int MASK_BIT = 7;
  localparam int AE_BIT   = 7;
  localparam int ABE_BIT  = 5;
  localparam int WF_BIT   = 7;
  localparam int AF_BIT   = 6;
  localparam int BLF_BIT  = 4;

  // field 0 seconds, 1 minutes, 2 hours, 3 date
  function automatic int field_w(int idx);
    return (idx < 2) ? 7 : 6;
  endfunction

  function automatic int field_lsb(int idx);
    int sum;
    sum = 0;
    for (int k = 0; k < idx; k++) sum += field_w(k);
    return sum;
  endfunction

  localparam int CMP_W = field_lsb(NFIELD);
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         power_good,
  input  logic                         acc_sel,
  input  logic                         acc_wr,
  input  logic [AW-1:0]                acc_addr,
  input  logic [DW-1:0]                acc_wdata,
  output logic [NFIELD-1:0][DW-1:0]    alarm_q,
  output logic [DW-1:0]                inten_q
);
  logic                      power_q;
  logic                      pwr_rise;
  logic                      wr_en;
  logic [NFIELD-1:0][DW-1:0] alarm_n;
  logic [DW-1:0]             inten_n;

  always_comb begin
    wr_en    = acc_sel & acc_wr;
    pwr_rise = power_good & ~power_q;
    alarm_n  = alarm_q;
    for (int i = 0; i < NFIELD; i++) begin
      if (wr_en && (acc_addr == ADR_ALM_BASE + AW'(i))) alarm_n[i] = acc_wdata;
    end
    inten_n = inten_q;
    if (wr_en && (acc_addr == ADR_INTEN)) inten_n = acc_wdata;
    if (pwr_rise) begin
      inten_n[AE_BIT]  = 1'b0;
      inten_n[ABE_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_q <= 1'b0;
      alarm_q <= '0;
      inten_q <= '0;
    end else begin
      power_q <= power_good;
      alarm_q <= alarm_n;
      inten_q <= inten_n;
    end
  end

  // R7: enables are gone after power returns
  a_r7_powerup_clears_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_good) |=> (!inten_q[AE_BIT] && !inten_q[ABE_BIT]));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic [NFIELD-1:0] mask,
  input  logic [CMP_W-1:0]  alarm_cmp,
  input  logic [CMP_W-1:0]  time_cmp,
  output logic              hit
);
  logic [NFIELD-1:0] eq;
  logic [NFIELD-1:0] ordered;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    localparam int FW  = field_w(i);
    localparam int LSB = field_lsb(i);
    assign eq[i] = (alarm_cmp[LSB +: FW] == time_cmp[LSB +: FW]);
    // legal masks are thermometer codes: a cleared bit forces all lower bits clear
    if (i == 0) begin : g_first
      assign ordered[i] = 1'b1;
    end else begin : g_rest
      assign ordered[i] = ~mask[i-1] | mask[i];
    end
  end

  always_comb begin
    if (&ordered) hit = &(eq | mask);
    else          hit = 1'b1;
  end
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic hit,
  input  logic power_good,
  input  logic ae,
  input  logic abe,
  input  logic flag_sel,
  output logic af_q,
  output logic irq_drive
);
  logic flag_q;
  logic af_n;

  always_comb begin
    af_n = af_q;
    if (flag_q && !flag_sel) af_n = 1'b0;
    if (sec_tick && hit)     af_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      af_q   <= af_n;
      flag_q <= flag_sel;
    end
  end

  assign irq_drive = af_q & ae & (power_good | abe) & ~(flag_sel | flag_q);

  // R4: flag only rises after a tick
  a_r4_af_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af_q) |-> $past(sec_tick));
  // R5: pin needs the flag and the enable
  a_r5_irq_needs_ae: assert property (@(posedge clk) disable iff (!rst_n)
    irq_drive |-> (af_q && ae));
  // R6: backup operation also needs the backup enable
  a_r6_backup_needs_abe: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_drive && !power_good) |-> abe);
  // R9: released during a flags access
  a_r9_release_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sel |-> !irq_drive);
  // R9: flag cleared once the access has ended
  a_r9_clear_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_sel && !sec_tick) |=> !af_q);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sec_tick,
  input  logic [field_w(0)-1:0]   tm_sec,
  input  logic [field_w(1)-1:0]   tm_min,
  input  logic [field_w(2)-1:0]   tm_hour,
  input  logic [field_w(3)-1:0]   tm_date,
  input  logic                    power_good,
  input  logic                    wdog_flag,
  input  logic                    batt_low,
  input  logic                    acc_sel,
  input  logic                    acc_wr,
  input  logic [AW-1:0]           acc_addr,
  input  logic [DW-1:0]           acc_wdata,
  output logic [DW-1:0]           acc_rdata,
  output logic                    irq_drive
);
  logic [NFIELD-1:0][DW-1:0] alarm_q;
  logic [DW-1:0]             inten_q;
  logic [NFIELD-1:0]         mask;
  logic [CMP_W-1:0]          alarm_cmp;
  logic [CMP_W-1:0]          time_cmp;
  logic                      hit;
  logic                      af_q;
  logic                      flag_sel;

  alarm_regs i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_good (power_good),
    .acc_sel    (acc_sel),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .alarm_q    (alarm_q),
    .inten_q    (inten_q)
  );

  for (genvar i = 0; i < NFIELD; i++) begin : g_pack
    localparam int FW  = field_w(i);
    localparam int LSB = field_lsb(i);
    assign alarm_cmp[LSB +: FW] = alarm_q[i][FW-1:0];
    assign mask[i]              = alarm_q[i][MASK_BIT];
  end
  assign time_cmp = {tm_date, tm_hour, tm_min, tm_sec};

  alarm_match i_match (
    .mask      (mask),
    .alarm_cmp (alarm_cmp),
    .time_cmp  (time_cmp),
    .hit       (hit)
  );

  assign flag_sel = acc_sel & (acc_addr == ADR_FLAGS);

  alarm_irq i_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .hit        (hit),
    .power_good (power_good),
    .ae         (inten_q[AE_BIT]),
    .abe        (inten_q[ABE_BIT]),
    .flag_sel   (flag_sel),
    .af_q       (af_q),
    .irq_drive  (irq_drive)
  );

  always_comb begin
    acc_rdata = '0;
    if (acc_addr == ADR_FLAGS) begin
      acc_rdata[WF_BIT]  = wdog_flag;
      acc_rdata[AF_BIT]  = af_q;
      acc_rdata[BLF_BIT] = batt_low;
    end
    if (acc_addr == ADR_INTEN) acc_rdata = inten_q;
    for (int i = 0; i < NFIELD; i++) begin
      if (acc_addr == ADR_ALM_BASE + AW'(i)) acc_rdata = alarm_q[i];
    end
  end
endmodule

// File: tb/test_alarm_irq_ctrl.sv
module test_alarm_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sec_tick;
  logic [6:0] tm_sec, tm_min;
  logic [5:0] tm_hour, tm_date;
  logic       power_good, wdog_flag, batt_low;
  logic       acc_sel, acc_wr;
  logic [3:0] acc_addr;
  logic [7:0] acc_wdata;
  logic [7:0] acc_rdata;
  logic       irq_drive;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq_ctrl i_alarm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_date(tm_date),
    .power_good(power_good), .wdog_flag(wdog_flag), .batt_low(batt_low),
    .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_drive(irq_drive)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_sel = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_sel = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic exp;
    rst_n = 1'b0; sec_tick = 1'b0; power_good = 1'b1;
    wdog_flag = 1'b0; batt_low = 1'b0;
    acc_sel = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    tm_sec = 7'h45; tm_min = 7'h37; tm_hour = 6'h23; tm_date = 6'h31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 check("R1 irq", {7'd0, irq_drive}, 8'h00);
    for (int a = 0; a <= 6; a++) begin
      if (a == 1) continue;
      rd(4'(a), d);
      check("R1 register", d, 8'h00);
    end

    // R2/R3 sweep over every mask pattern and every field-match combination
    for (int m = 0; m < 16; m++) begin
      wr(4'h2, {m[0], 7'h45});
      wr(4'h3, {m[1], 7'h37});
      wr(4'h4, {m[2], 7'h23});
      wr(4'h5, {m[3], 7'h31});
      for (int f = 0; f < 16; f++) begin
        tm_sec  = f[0] ? 7'h45 : 7'h44;
        tm_min  = f[1] ? 7'h37 : 7'h36;
        tm_hour = f[2] ? 6'h23 : 6'h22;
        tm_date = f[3] ? 6'h31 : 6'h30;
        case (4'(m))
          4'b1110: exp = f[0];
          4'b1100: exp = f[0] & f[1];
          4'b1000: exp = f[0] & f[1] & f[2];
          4'b0000: exp = f[0] & f[1] & f[2] & f[3];
          default: exp = 1'b1;
        endcase
        tick();
        rd(4'h0, d);
        if (m == 15 || !(m == 14 || m == 12 || m == 8 || m == 0))
          check("R2 once-per-second mask", {7'd0, d[6]}, {7'd0, exp});
        else
          check("R3 field match", {7'd0, d[6]}, {7'd0, exp});
      end
    end

    // R10 register storage
    wr(4'h6, 8'h5A); rd(4'h6, d); check("R10 inten 5A", d, 8'h5A);
    wr(4'h6, 8'hFF); rd(4'h6, d); check("R10 inten FF", d, 8'hFF);
    wr(4'h3, 8'hA5); rd(4'h3, d); check("R10 alarm reg", d, 8'hA5);
    wr(4'h2, 8'h80); wr(4'h3, 8'h80); wr(4'h4, 8'h80); wr(4'h5, 8'h80);
    wr(4'h6, 8'h00);
    rd(4'h0, d);

    // R4 flag only on tick, one cycle latency
    @(negedge clk);
    wr(4'h6, 8'h80);
    repeat (3) @(negedge clk);
    #1 check("R4 no tick no flag", {7'd0, irq_drive}, 8'h00);
    @(negedge clk); sec_tick = 1'b1;
    #1 check("R4 not before edge", {7'd0, irq_drive}, 8'h00);
    @(negedge clk); sec_tick = 1'b0;
    #1 check("R4 set after tick", {7'd0, irq_drive}, 8'h01);

    // R5 enable gating under main power
    wr(4'h6, 8'h00);
    #1 check("R5 ae off", {7'd0, irq_drive}, 8'h00);
    wr(4'h6, 8'h80);
    #1 check("R5 ae on", {7'd0, irq_drive}, 8'h01);

    // R9 release during flags access, clear after it
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = 4'h0;
    #1 check("R9 released in access", {7'd0, irq_drive}, 8'h00);
    check("R9 flag still set", {7'd0, acc_rdata[6]}, 8'h01);
    @(negedge clk); acc_sel = 1'b0;
    #1 check("R9 released at end", {7'd0, irq_drive}, 8'h00);
    @(negedge clk);
    #1 check("R9 stays released", {7'd0, irq_drive}, 8'h00);
    rd(4'h0, d); check("R9 flag cleared", {7'd0, d[6]}, 8'h00);

    // R8 flags layout and write discard
    wdog_flag = 1'b1; batt_low = 1'b1;
    tick();
    rd(4'h0, d); check("R8 flags read", d, 8'hD0);
    wr(4'h0, 8'hFF);
    rd(4'h0, d); check("R8 write discarded", d, 8'h90);
    wdog_flag = 1'b0; batt_low = 1'b0;

    // R6 backup enable
    tick();
    @(negedge clk); power_good = 1'b0;
    #1 check("R6 backup needs abe", {7'd0, irq_drive}, 8'h00);
    wr(4'h6, 8'hA0);
    #1 check("R6 backup ae+abe", {7'd0, irq_drive}, 8'h01);
    wr(4'h6, 8'h20);
    #1 check("R6 abe without ae", {7'd0, irq_drive}, 8'h00);

    // R7 power-up clears enables, alarm still sets flag
    wr(4'h6, 8'hBF);
    rd(4'h0, d);
    @(negedge clk);
    power_good = 1'b1; sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    #1 check("R7 irq off after power-up", {7'd0, irq_drive}, 8'h00);
    rd(4'h6, d); check("R7 enables cleared", d, 8'h1F);
    rd(4'h0, d); check("R7 flag set at power-up", {7'd0, d[6]}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule